// File: doc/BRIEF.md
# Synchronous Burst Bus Target

This block is the responder side of a clocked, shared-bus transfer scheme with active-low framing. An initiator opens a transaction by pulling `frame_n` low for one cycle. In that cycle it places a word address on `ad_in` and an operation code on `cmd`. The target samples both on that edge. If the address falls inside its window and the code is one it serves, it claims the transaction.

After the address phase comes a data phase of any length. One word moves on every rising edge where the initiator's ready (`irdy_n`) and the target's ready (`trdy_n`) are both low. Each beat steps to the next word of a small internal memory. The target holds `trdy_n` high for a fixed number of cycles before the first beat. On a read it also leaves the data lines undriven for one turnaround cycle before it drives them. The initiator marks the last beat by raising `frame_n` while keeping `irdy_n` low. After that beat the target releases every line it drives.

The address and data lines that would be shared on a board are split into `ad_in`, `ad_out` and the drive enable `ad_oe`. The surrounding pad logic combines them.

Top module: `burst_target`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `trdy_n` is 1 and `ad_oe` is 0.
- R2: The target starts a transaction on the first edge where it is idle and samples `frame_n` = 0. On that edge it takes `ad_in` as a word address and takes `cmd`. Code 4'h6 means read and code 4'h7 means write. Any other code gets no response.
- R3: Addresses from BASE_ADDR to BASE_ADDR+DEPTH-1 are served. For any other address, or an unserved code, `trdy_n` stays 1 and `ad_oe` stays 0 until the initiator returns `frame_n` and `irdy_n` to 1. The memory is left unchanged.
- R4: A beat happens only on an edge with `irdy_n` = 0 and `trdy_n` = 0. On a write beat, `ad_in` is stored at the current word. On a read beat, `ad_out` carries the current word.
- R5: Each beat advances the word index by one. Past the last word of the window, the index wraps to the first word (modulo DEPTH).
- R6: After the address edge, a write's `trdy_n` first goes low in cycle INIT_WAIT+1. A read's `trdy_n` first goes low in cycle INIT_WAIT+2. Once low, it stays low until the final beat.
- R7: On a read, the cycle after the address phase has `ad_oe` = 0 and `trdy_n` = 1 (turnaround). Whenever a read has `trdy_n` low, `ad_oe` is 1.
- R8: While the initiator holds `irdy_n` = 1, no beat happens, the word index does not move and `trdy_n` keeps its level.
- R9: The beat taken with `frame_n` = 1 is the last one. In the next cycle `trdy_n` is 1 and `ad_oe` is 0, and the target accepts a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator frame, low while a transaction is open |
| irdy_n | input | 1 | Initiator ready, low when it can move a word |
| cmd | input | 4 | Operation code, valid in the address phase |
| ad_in | input | AD_W | Address in the address phase, write data afterwards |
| ad_out | output | AD_W | Read data, zero while not driven |
| ad_oe | output | 1 | Target drives the data lines |
| trdy_n | output | 1 | Target ready, low when it can move a word |

## Verification
A wrong word index shows up as a mismatched read word on the very next read beat that covers the affected location. A write to the wrong index shows up when that part of the window is read back. If the target lingers in its data state, `trdy_n` stays low or `ad_oe` stays high in the cycle right after the final beat. If it misses the turnaround or miscounts the initial wait, `trdy_n` or `ad_oe` differs in one specific early cycle of the transaction. The bench checks each cycle of every transaction, so these errors show within one clock of their cause.

// File: rtl/btgt_pkg.sv
package btgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WAIT,
    ST_DATA,
    ST_SKIP
  } tstate_e;

  localparam logic [3:0] CMD_RD = 4'h6;
  localparam logic [3:0] CMD_WR = 4'h7;
endpackage

// File: rtl/btgt_decode.sv
module btgt_decode #(
  parameter int                 AD_W      = 32,
  parameter logic [AD_W-1:0]    BASE_ADDR = 32'h0000_0100,
  parameter int                 DEPTH     = 16,
  localparam int                IDX_W     = $clog2(DEPTH)
) (
  input  logic [AD_W-1:0]  addr,
  input  logic [3:0]       cmd,
  output logic             hit,
  output logic             is_rd,
  output logic [IDX_W-1:0] idx
);
  import btgt_pkg::*;

  logic [AD_W:0]   lo_ext;
  logic [AD_W:0]   hi_ext;
  logic [AD_W:0]   a_ext;
  logic [AD_W-1:0] offset;
  logic            in_win;
  logic            known;

  always_comb begin
    a_ext  = {1'b0, addr};
    lo_ext = {1'b0, BASE_ADDR};
    hi_ext = lo_ext + (AD_W+1)'(DEPTH);
    in_win = (a_ext >= lo_ext) && (a_ext < hi_ext);
    known  = (cmd == CMD_RD) || (cmd == CMD_WR);
    hit    = in_win && known;
    is_rd  = (cmd == CMD_RD);
    offset = addr - BASE_ADDR;
    idx    = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/btgt_mem.sv
module btgt_mem #(
  parameter int  AD_W  = 32,
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [AD_W-1:0]  wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [AD_W-1:0]  rdata
);
  logic [AD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[widx] <= wdata;
    end
  end

  assign rdata = store[ridx];

  AST_WR_IDX_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(widx)); // R4
endmodule

// File: rtl/btgt_seq.sv
module btgt_seq #(
  parameter int  INIT_WAIT = 1,
  localparam int CNT_W     = (INIT_WAIT > 1) ? $clog2(INIT_WAIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit,
  input  logic is_rd,
  output logic capture,
  output logic beat,
  output logic rd_mode,
  output logic trdy_n,
  output logic ad_oe
);
  import btgt_pkg::*;

  tstate_e    state_q, state_d;
  logic       trdy_n_q, trdy_n_d;
  logic       oe_q, oe_d;
  logic       rd_q, rd_d;
  logic       last;
  logic       cnt_zero;
  logic       after_turn;

  assign capture = (state_q == ST_IDLE) && !frame_n;
  assign beat    = (state_q == ST_DATA) && !irdy_n && !trdy_n_q;
  assign last    = beat && frame_n;

  generate
    if (INIT_WAIT > 0) begin : g_wait
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;
      assign after_turn = 1'b1;
      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (state_d == ST_WAIT && state_q != ST_WAIT) begin
          cnt_en = 1'b1;
          cnt_d  = CNT_W'(INIT_WAIT - 1);
        end else if (state_q == ST_WAIT) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end
      assign cnt_zero = (cnt_q == '0);
    end else begin : g_nowait
      assign after_turn = 1'b0;
      assign cnt_zero   = 1'b1;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (capture) begin
          if (!hit)            state_d = ST_SKIP;
          else if (is_rd)      state_d = ST_TURN;
          else if (after_turn) state_d = ST_WAIT;
          else                 state_d = ST_DATA;
        end
      end
      ST_TURN: state_d = after_turn ? ST_WAIT : ST_DATA;
      ST_WAIT: if (cnt_zero) state_d = ST_DATA;
      ST_DATA: if (last) state_d = ST_IDLE;
      ST_SKIP: if (frame_n && irdy_n) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rd_d     = (capture && hit) ? is_rd : rd_q;
    trdy_n_d = (state_d != ST_DATA);
    oe_d     = rd_d && ((state_d == ST_WAIT) || (state_d == ST_DATA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      trdy_n_q <= 1'b1;
      oe_q     <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      trdy_n_q <= trdy_n_d;
      oe_q     <= oe_d;
      if (capture) begin
        rd_q <= rd_d;
      end
    end
  end

  assign rd_mode = rd_q;
  assign trdy_n  = trdy_n_q;
  assign ad_oe   = oe_q;

  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && frame_n) |=> (trdy_n_q && !oe_q)); // R9
  AST_TRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_q && !(beat && frame_n)) |=> !trdy_n_q); // R8
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && hit && is_rd) |=> (!oe_q && trdy_n_q)); // R7
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !hit) |=> (trdy_n_q && !oe_q)); // R3
endmodule

// File: rtl/burst_target.sv
module burst_target #(
  parameter int              AD_W      = 32,
  parameter logic [AD_W-1:0] BASE_ADDR = 32'h0000_0100,
  parameter int              DEPTH     = 16,
  parameter int              INIT_WAIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [3:0]      cmd,
  input  logic [AD_W-1:0] ad_in,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe,
  output logic            trdy_n
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             hit;
  logic             is_rd;
  logic [IDX_W-1:0] dec_idx;
  logic             capture;
  logic             beat;
  logic             rd_mode;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [AD_W-1:0]  rdata;

  btgt_decode #(.AD_W(AD_W), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH)) u_dec (
    .addr (ad_in),
    .cmd  (cmd),
    .hit  (hit),
    .is_rd(is_rd),
    .idx  (dec_idx)
  );

  btgt_seq #(.INIT_WAIT(INIT_WAIT)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .frame_n(frame_n),
    .irdy_n (irdy_n),
    .hit    (hit),
    .is_rd  (is_rd),
    .capture(capture),
    .beat   (beat),
    .rd_mode(rd_mode),
    .trdy_n (trdy_n),
    .ad_oe  (ad_oe)
  );

  always_comb begin
    idx_en = capture || beat;
    idx_d  = capture ? dec_idx : (idx_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  btgt_mem #(.AD_W(AD_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (beat && !rd_mode),
    .widx (idx_q),
    .wdata(ad_in),
    .ridx (idx_q),
    .rdata(rdata)
  );

  assign ad_out = ad_oe ? rdata : '0;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (idx_q == $past(idx_q) + 1'b1)); // R5
  AST_IDX_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && irdy_n) |=> $stable(idx_q)); // R8
  AST_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && rd_mode) |-> ad_oe); // R7
endmodule

// File: tb/burst_target_test.sv
module burst_target_test;
  localparam int          AD_W      = 32;
  localparam logic [31:0] BASE_ADDR = 32'h0000_0100;
  localparam int          DEPTH     = 16;
  localparam int          INIT_WAIT = 1;
  localparam logic [3:0]  C_RD      = 4'h6;
  localparam logic [3:0]  C_WR      = 4'h7;

  logic            clk;
  logic            rst_n;
  logic            frame_n;
  logic            irdy_n;
  logic [3:0]      cmd;
  logic [AD_W-1:0] ad_in;
  logic [AD_W-1:0] ad_out;
  logic            ad_oe;
  logic            trdy_n;

  int checks;
  int errors;
  logic [AD_W-1:0] ref_mem [DEPTH];

  burst_target #(.AD_W(AD_W), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH),
                 .INIT_WAIT(INIT_WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cmd(cmd), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int first_ready(input bit rd);
    return (rd ? 2 : 1) + INIT_WAIT;
  endfunction

  function automatic int wrap_idx(input int i);
    return i % DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic burst(input logic [31:0] addr, input logic [3:0] c,
                       input int len, input int stall_pct, input bit hit);
    int  cyc;
    int  beats;
    int  idx;
    bit  rd;
    bit  stalled;
    logic [31:0] d;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cmd = c;
    if (!hit) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; ad_in = $urandom; cmd = 4'h0;
        chk(trdy_n == 1'b1, "R3 trdy on miss", {31'd0, trdy_n}, 32'd1);
        chk(ad_oe == 1'b0, "R3 oe on miss", {31'd0, ad_oe}, 32'd0);
      end
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1;
      return;
    end
    rd = (c == C_RD);
    idx = int'(addr - BASE_ADDR);
    cyc = 0; beats = 0; stalled = 1'b0;
    while (beats < len) begin
      @(negedge clk);
      cyc++;
      cmd = 4'h0;
      if (cyc < first_ready(rd))
        chk(trdy_n == 1'b1, "R6 early trdy", {31'd0, trdy_n}, 32'd1);
      if (cyc == first_ready(rd))
        chk(trdy_n == 1'b0, "R6 first trdy", {31'd0, trdy_n}, 32'd0);
      if (rd && cyc == 1)
        chk(ad_oe == 1'b0, "R7 turnaround", {31'd0, ad_oe}, 32'd0);
      if (stalled)
        chk(trdy_n == 1'b0, "R8 trdy kept", {31'd0, trdy_n}, 32'd0);
      if (frame_n) irdy_n = 1'b0;
      else irdy_n = (($urandom % 100) < stall_pct) ? 1'b1 : 1'b0;
      if (!irdy_n && beats == len - 1) frame_n = 1'b1;
      d = $urandom;
      ad_in = rd ? 32'h0 : d;
      stalled = irdy_n && !trdy_n;
      if (!irdy_n && !trdy_n) begin
        if (rd) begin
          chk(ad_oe == 1'b1, "R7 read drive", {31'd0, ad_oe}, 32'd1);
          chk(ad_out == ref_mem[wrap_idx(idx)], "R4/R5 read word", ad_out,
              ref_mem[wrap_idx(idx)]);
        end else begin
          ref_mem[wrap_idx(idx)] = d;
        end
        beats++;
        idx++;
      end
    end
    @(negedge clk);
    chk(trdy_n == 1'b1, "R9 trdy release", {31'd0, trdy_n}, 32'd1);
    chk(ad_oe == 1'b0, "R9 oe release", {31'd0, ad_oe}, 32'd0);
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: bus hung actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; errors = 0;
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cmd = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk(trdy_n == 1'b1, "R1 trdy in reset", {31'd0, trdy_n}, 32'd1);
    chk(ad_oe == 1'b0, "R1 oe in reset", {31'd0, ad_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trdy_n == 1'b1, "R1 trdy after reset", {31'd0, trdy_n}, 32'd1);
    chk(ad_oe == 1'b0, "R1 oe after reset", {31'd0, ad_oe}, 32'd0);

    // R2 R4: fill the window, then read it all back without stalls
    burst(BASE_ADDR, C_WR, DEPTH, 0, 1'b1);
    burst(BASE_ADDR, C_RD, DEPTH, 0, 1'b1);
    // single-beat bursts
    burst(BASE_ADDR + 32'd3, C_WR, 1, 0, 1'b1);
    burst(BASE_ADDR + 32'd3, C_RD, 1, 0, 1'b1);
    // R5: bursts that run past the last word
    burst(BASE_ADDR + DEPTH - 2, C_WR, 5, 30, 1'b1);
    burst(BASE_ADDR + DEPTH - 3, C_RD, 7, 30, 1'b1);
    // R3: outside the window on both sides and an unserved code
    burst(BASE_ADDR + DEPTH, C_WR, 1, 0, 1'b0);
    burst(BASE_ADDR - 32'd1, C_WR, 1, 0, 1'b0);
    burst(BASE_ADDR + 32'd2, 4'h2, 1, 0, 1'b0);
    burst(32'h0, C_RD, 1, 0, 1'b0);
    burst(BASE_ADDR, C_RD, DEPTH, 0, 1'b1);
    // R8: heavy initiator stalls
    burst(BASE_ADDR + 32'd5, C_WR, 8, 70, 1'b1);
    burst(BASE_ADDR + 32'd5, C_RD, 8, 70, 1'b1);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int off;
      int len;
      bit r;
      off = int'($urandom % DEPTH);
      len = 1 + int'($urandom % 20);
      r   = $urandom % 2;
      burst(BASE_ADDR + off, r ? C_RD : C_WR, len, int'($urandom % 60), 1'b1);
    end
    burst(BASE_ADDR, C_RD, DEPTH, 20, 1'b1);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule